// File: doc/BRIEF.md
# Lane Address Broadcast Detector

This block examines one memory instruction issued across a group of lanes and decides whether every active lane points at the same aligned 32-bit word. In that case the memory system only needs a single request, sent from lane 0, instead of one request per active lane. The block reports a duplicate flag, the number of requests (and therefore responses) to expect, and a per-lane request-enable vector that the request issue logic uses directly.

The decision is purely combinational. A parameter selects whether the result passes straight through or is held in one output register stage. Data enters and leaves on valid/ready handshakes. With the register present, the input is accepted whenever the output stage is empty or is being drained in the same cycle (`in_ready = !out_valid || out_ready`). The output stays unchanged while `out_valid` is high and `out_ready` is low. Without the register, `out_valid` follows `in_valid` and `in_ready` follows `out_ready`. The `dedup_en` pin is a plain configuration level sampled together with the input beat.

Top module: `lane_bcast_detect`

## Requirements
- R1: Two lane addresses count as equal when they differ only in bits [1:0]. A difference in any bit from 2 upward makes them unequal.
- R2: When lane 0 is inactive (`in_mask[0]` = 0), `out_dup` is 0 whatever the other lanes hold.
- R3: With lane 0 active and `dedup_en` = 1, `out_dup` is 1 exactly when every active lane's aligned address equals lane 0's aligned address.
- R4: When `out_dup` is 1, `out_count` is 1 and `out_req_en` has only bit 0 set.
- R5: When `out_dup` is 0, `out_count` equals the number of ones in the input mask and `out_req_en` equals the input mask. Bit j of the mask and of `out_req_en` both belong to lane j.
- R6: The address of an inactive lane has no influence on any output, and an inactive lane's `out_req_en` bit is always 0.
- R7: When `dedup_en` is 0, `out_dup` is 0.
- R8: With the output register present, a result that is presented but not accepted keeps `out_valid`, `out_dup`, `out_count` and `out_req_en` unchanged, and `in_ready` is 0 until `out_ready` returns.
- R9: While reset is asserted and right after it, `out_valid` is 0.
- R10: An all-zero mask gives `out_dup` = 0, `out_count` = 0 and `out_req_en` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dedup_en | input | 1 | Enables duplicate detection |
| in_valid | input | 1 | Input beat valid |
| in_ready | output | 1 | Block can accept the input beat |
| in_mask | input | LANES | Active lanes, bit j is lane j |
| in_addr | input | LANES*ADDR_W | Byte addresses, lane j at [j*ADDR_W +: ADDR_W] |
| out_valid | output | 1 | Result valid |
| out_ready | input | 1 | Consumer accepts the result |
| out_dup | output | 1 | All active lanes hit lane 0's word |
| out_count | output | $clog2(LANES+1) | Number of requests to issue |
| out_req_en | output | LANES | Per-lane request enable |

## Verification
The hardest case to reach is an output held under back-pressure while a different beat waits at the input. The stimulus must stall `out_ready`, present a new beat with different lanes and addresses, and confirm that the registered result stays the same. Releasing `out_ready` must then retire the old result and capture the new one on the same edge. The vectors also place lane addresses that differ only in bits [1:0], addresses that differ in one high bit, and wild addresses on inactive lanes, so that each alignment and masking rule is exercised on its own.

// File: rtl/lbd_pkg.sv
package lbd_pkg;
  function automatic int unsigned lbd_cnt_w(input int unsigned lanes);
    return $clog2(lanes + 1);
  endfunction
endpackage

// File: rtl/lbd_word_match.sv
module lbd_word_match #(
  parameter int unsigned LANES      = 4,
  parameter int unsigned ADDR_W     = 32,
  parameter int unsigned ALIGN_BITS = 2
) (
  input  logic [LANES-1:0]        mask,
  input  logic [LANES*ADDR_W-1:0] addr,
  output logic [LANES-1:0]        hit
);
  localparam logic [ADDR_W-1:0] KEEP = ~((ADDR_W'(1) << ALIGN_BITS) - ADDR_W'(1));

  logic [ADDR_W-1:0] ref_word;
  assign ref_word = addr[ADDR_W-1:0] & KEEP;

  for (genvar j = 0; j < LANES; j++) begin : g_lane
    if (j == 0) begin : g_ref
      assign hit[j] = mask[j];
    end else begin : g_cmp
      logic [ADDR_W-1:0] word;
      assign word   = addr[j*ADDR_W +: ADDR_W] & KEEP;
      assign hit[j] = mask[j] && (word == ref_word);
    end
  end
endmodule

// File: rtl/lbd_popcount.sv
module lbd_popcount #(
  parameter int unsigned LANES = 4,
  parameter int unsigned CNT_W = 3
) (
  input  logic [LANES-1:0] bits,
  output logic [CNT_W-1:0] cnt
);
  localparam int unsigned LEVELS = $clog2(LANES);
  localparam int unsigned LEAVES = 1 << LEVELS;
  localparam int unsigned NODES  = 2 * LEAVES - 1;

  logic [CNT_W-1:0] node [NODES];

  for (genvar k = 0; k < LEAVES; k++) begin : g_leaf
    if (k < LANES) begin : g_used
      assign node[LEAVES-1+k] = CNT_W'(bits[k]);
    end else begin : g_pad
      assign node[LEAVES-1+k] = '0;
    end
  end

  for (genvar i = 0; i < LEAVES - 1; i++) begin : g_sum
    assign node[i] = node[2*i+1] + node[2*i+2];
  end

  assign cnt = node[0];
endmodule

// File: rtl/lbd_out_stage.sv
module lbd_out_stage #(
  parameter int unsigned W       = 8,
  parameter bit          REG_OUT = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data
);
  if (REG_OUT) begin : g_reg
    logic         vld_q;
    logic [W-1:0] dat_q;
    assign in_ready = !vld_q || out_ready;
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        vld_q <= 1'b0;
        dat_q <= '0;
      end else if (in_ready) begin
        vld_q <= in_valid;
        if (in_valid) dat_q <= in_data;
      end
    end
    assign out_valid = vld_q;
    assign out_data  = dat_q;
  end else begin : g_pass
    logic unused_clk;
    assign unused_clk = clk ^ rst_n;
    assign in_ready  = out_ready;
    assign out_valid = in_valid;
    assign out_data  = in_data;
  end
endmodule

// File: rtl/lane_bcast_detect.sv
module lane_bcast_detect
  import lbd_pkg::*;
#(
  parameter int unsigned LANES      = 4,
  parameter int unsigned ADDR_W     = 32,
  parameter int unsigned ALIGN_BITS = 2,
  parameter bit          REG_OUT    = 1'b1,
  parameter int unsigned CNT_W      = lbd_cnt_w(LANES)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    dedup_en,
  input  logic                    in_valid,
  output logic                    in_ready,
  input  logic [LANES-1:0]        in_mask,
  input  logic [LANES*ADDR_W-1:0] in_addr,
  output logic                    out_valid,
  input  logic                    out_ready,
  output logic                    out_dup,
  output logic [CNT_W-1:0]        out_count,
  output logic [LANES-1:0]        out_req_en
);
  localparam int unsigned RES_W = 1 + CNT_W + LANES;

  logic [LANES-1:0] hit;
  logic [CNT_W-1:0] n_active, n_hit;
  logic             dup;
  logic [CNT_W-1:0] count;
  logic [LANES-1:0] req_en;
  logic [RES_W-1:0] res_d, res_q;

  lbd_word_match #(.LANES(LANES), .ADDR_W(ADDR_W), .ALIGN_BITS(ALIGN_BITS)) u_match (
    .mask(in_mask), .addr(in_addr), .hit(hit)
  );

  lbd_popcount #(.LANES(LANES), .CNT_W(CNT_W)) u_pc_mask (.bits(in_mask), .cnt(n_active));
  lbd_popcount #(.LANES(LANES), .CNT_W(CNT_W)) u_pc_hit  (.bits(hit),     .cnt(n_hit));

  always_comb begin
    dup    = dedup_en && in_mask[0] && (n_hit == n_active);
    count  = dup ? CNT_W'(1) : n_active;
    req_en = dup ? LANES'(1) : in_mask;
  end

  assign res_d = {dup, count, req_en};

  lbd_out_stage #(.W(RES_W), .REG_OUT(REG_OUT)) u_out (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(res_d),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(res_q)
  );

  assign {out_dup, out_count, out_req_en} = res_q;
endmodule

// File: rtl/lbd_checker.sv
module lbd_checker #(
  parameter int unsigned LANES   = 4,
  parameter int unsigned CNT_W   = 3,
  parameter bit          REG_OUT = 1'b1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             out_valid,
  input logic             out_ready,
  input logic             in_ready,
  input logic             out_dup,
  input logic [CNT_W-1:0] out_count,
  input logic [LANES-1:0] out_req_en
);
  // R4: a duplicate result asks for exactly one request
  a_r4_dup_count_one: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_dup |-> out_count == CNT_W'(1));
  // R4: that single request comes from lane 0
  a_r4_dup_lane0_only: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_dup |-> out_req_en[0] && $onehot0(out_req_en));
  // R5: without a duplicate the count matches the enabled lanes
  a_r5_count_matches_en: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_dup |-> 32'(out_count) == 32'($countones(out_req_en)));
  // R10: a zero count never comes with a duplicate
  a_r10_zero_not_dup: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_count == '0 |-> !out_dup && out_req_en == '0);

  if (REG_OUT) begin : g_hold
    // R8: a stalled result holds still
    a_r8_hold_on_stall: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && !out_ready |=> out_valid && $stable(out_dup) &&
      $stable(out_count) && $stable(out_req_en));
    // R8: the input is blocked while the result is stalled
    a_r8_block_input: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && !out_ready |-> !in_ready);
  end
endmodule

bind lane_bcast_detect lbd_checker #(.LANES(LANES), .CNT_W(CNT_W), .REG_OUT(REG_OUT)) u_chk (
  .clk(clk), .rst_n(rst_n), .out_valid(out_valid), .out_ready(out_ready),
  .in_ready(in_ready), .out_dup(out_dup), .out_count(out_count), .out_req_en(out_req_en)
);

// File: tb/sim_lane_bcast_detect.sv
`timescale 1ns/1ps
module sim_lane_bcast_detect;
  localparam int unsigned LANES = 4;
  localparam int unsigned AW    = 32;
  localparam int unsigned CW    = 3;

  typedef struct packed {
    logic            en;
    logic [3:0]      mask;
    logic [127:0]    addr;   // {lane3, lane2, lane1, lane0}
    logic            dup;
    logic [2:0]      cnt;
    logic [3:0]      req;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    // R3/R4: all lanes same address
    '{1'b1, 4'hF, {32'h1000, 32'h1000, 32'h1000, 32'h1000}, 1'b1, 3'd1, 4'h1},
    // R1: differ only in bits [1:0]
    '{1'b1, 4'hF, {32'h1003, 32'h1002, 32'h1001, 32'h1000}, 1'b1, 3'd1, 4'h1},
    // R5: lane 2 in next word
    '{1'b1, 4'hF, {32'h1000, 32'h1004, 32'h1000, 32'h1000}, 1'b0, 3'd4, 4'hF},
    // R2: lane 0 inactive
    '{1'b1, 4'hE, {32'h1000, 32'h1000, 32'h1000, 32'h1000}, 1'b0, 3'd3, 4'hE},
    // R7: detection disabled
    '{1'b0, 4'hF, {32'h1000, 32'h1000, 32'h1000, 32'h1000}, 1'b0, 3'd4, 4'hF},
    // R6: inactive lanes carry wild addresses
    '{1'b1, 4'h5, {32'hBEEF0000, 32'h2003, 32'hDEAD0000, 32'h2000}, 1'b1, 3'd1, 4'h1},
    // R10: empty mask
    '{1'b1, 4'h0, {32'h1, 32'h2, 32'h3, 32'h4}, 1'b0, 3'd0, 4'h0},
    // R3: single active lane 0
    '{1'b1, 4'h1, {32'h9, 32'h8, 32'h7, 32'h4000}, 1'b1, 3'd1, 4'h1},
    // R5: two lanes, different words
    '{1'b1, 4'h9, {32'h3004, 32'h0, 32'h0, 32'h3000}, 1'b0, 3'd2, 4'h9},
    // R1: one high bit differs
    '{1'b1, 4'hF, {32'h1000, 32'h00011000, 32'h1000, 32'h1000}, 1'b0, 3'd4, 4'hF}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic dedup_en = 1'b0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [LANES-1:0] in_mask = '0;
  logic [LANES*AW-1:0] in_addr = '0;
  logic out_valid;
  logic out_ready = 1'b1;
  logic out_dup;
  logic [CW-1:0] out_count;
  logic [LANES-1:0] out_req_en;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  lane_bcast_detect #(.LANES(LANES), .ADDR_W(AW), .ALIGN_BITS(2), .REG_OUT(1'b1)) u0 (
    .clk(clk), .rst_n(rst_n), .dedup_en(dedup_en),
    .in_valid(in_valid), .in_ready(in_ready), .in_mask(in_mask), .in_addr(in_addr),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_dup(out_dup), .out_count(out_count), .out_req_en(out_req_en)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic drive(input logic en, input logic [3:0] m, input logic [127:0] a);
    dedup_en = en;
    in_mask  = m;
    in_addr  = a;
    in_valid = 1'b1;
  endtask

  task automatic check_out(input string req, input logic d, input logic [2:0] c, input logic [3:0] r);
    chk({req, " valid"}, int'(out_valid), 1);
    chk({req, " dup"},   int'(out_dup), int'(d));
    chk({req, " count"}, int'(out_count), int'(c));
    chk({req, " req_en"}, int'(out_req_en), int'(r));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R9 valid in reset", int'(out_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R9 valid after reset", int'(out_valid), 0);

    for (int i = 0; i < NV; i++) begin
      drive(VECS[i].en, VECS[i].mask, VECS[i].addr);
      @(negedge clk);
      in_valid = 1'b0;
      check_out($sformatf("vec%0d", i), VECS[i].dup, VECS[i].cnt, VECS[i].req);
    end

    // R6: wild addresses on inactive lanes 1 and 3 give the same result as tidy ones
    drive(1'b1, 4'h5, {32'h0, 32'h5004, 32'h0, 32'h5000});
    @(negedge clk);
    in_valid = 1'b0;
    check_out("R6 tidy", 1'b0, 3'd2, 4'h5);
    drive(1'b1, 4'h5, {32'h5000, 32'h5004, 32'h5000, 32'h5000});
    @(negedge clk);
    in_valid = 1'b0;
    check_out("R6 wild", 1'b0, 3'd2, 4'h5);

    // R8: back-pressure holds the result and blocks the input
    @(negedge clk);
    out_ready = 1'b0;
    drive(1'b1, 4'hF, {32'h7000, 32'h7000, 32'h7001, 32'h7000});
    @(negedge clk);
    check_out("R8 first", 1'b1, 3'd1, 4'h1);
    chk("R8 in_ready low", int'(in_ready), 0);
    drive(1'b1, 4'h6, {32'h0, 32'h8000, 32'h8000, 32'h0});
    @(negedge clk);
    check_out("R8 held", 1'b1, 3'd1, 4'h1);
    @(negedge clk);
    check_out("R8 held2", 1'b1, 3'd1, 4'h1);
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check_out("R8 next", 1'b0, 3'd2, 4'h6);
    @(negedge clk);
    chk("R8 drained", int'(out_valid), 0);

    // R9: reset clears a pending result
    out_ready = 1'b0;
    drive(1'b1, 4'hF, '0);
    @(negedge clk);
    in_valid = 1'b0;
    rst_n = 1'b0;
    @(negedge clk);
    chk("R9 cleared", int'(out_valid), 0);
    rst_n = 1'b1;
    out_ready = 1'b1;
    @(negedge clk);
    chk("R9 stays idle", int'(out_valid), 0);

    done = 1'b1;
  end

  initial begin
    fork
      begin wait (done); end
      begin
        repeat (5000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=hung expected=done");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule